// File: doc/BRIEF.md
# PWM Timer Channel with Selectable Shutdown Behaviour

This block is one pulse-width-modulation channel driven by a free-running up-counter. Software programs the channel over a small synchronous register bus. The registers are a period length, a duty length, and a control word that holds an enable bit, an output polarity bit and a shutdown-mode bit. While the channel is enabled, the counter runs from zero up to period minus one and then starts again at zero. The output sits at its active level while the count is below the duty value. For the rest of the period it sits at its inactive level.

No register has a shadow copy. A new duty, period or polarity value takes effect on the next clock, even in the middle of a period. When the channel is disabled, the counter is held at zero. The shutdown-mode bit then chooses what the output does. In abrupt mode the output is forced to its inactive level for the present polarity. In graceful mode the output is frozen at the level it had when the channel stopped.

Top module: `pwm_chan`

## Requirements
- R1: After synchronous reset, every register reads as zero, the count reads as zero and `pwm_out` is low.
- R2: The register map is as follows. Address 0 is control, with enable at bit 0, polarity at bit 1 and shutdown mode at bit 9. Address 1 is period and address 2 is duty, both 16 bits. Address 3 is the read-only count. Control bits that are not defined read as zero. `bus_rdata` shows the register selected by `bus_addr` one clock after that address is presented.
- R3: While enabled, the count steps from 0 to period-1 and then wraps to 0. A period of 0 holds the count at 0.
- R4: While enabled, `pwm_out` is at the active level whenever the count is below duty and at the inactive level otherwise. The output lags the count by one clock, so each period holds exactly `duty` active cycles when duty is at most period.
- R5: When duty is equal to or greater than period, the output is active for the whole period. When duty is 0, the output is never active.
- R6: A duty write takes effect on the next clock, without waiting for the end of the period.
- R7: When the polarity bit is 0 the active level is high. When it is 1 the active level is low. A change of polarity while enabled takes effect on the next clock.
- R8: If period is written below the current count, the count wraps to 0 on the next clock.
- R9: While disabled, the count reads 0. Re-enabling starts a new period from count 0.
- R10: With shutdown mode 1 (abrupt), a disabled channel drives the inactive level of the present polarity.
- R11: With shutdown mode 0 (graceful), a disabled channel holds `pwm_out` at its last level. Duty and polarity writes made while disabled leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address for both writes and reads |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pwm_out | output | 1 | PWM output line |

## Verification
The bench targets the cases where a shadowed design would behave differently. A duty raised in the middle of a period must drive the output active at once; a shadowed design would stay inactive until the period boundary. A period shrunk below the running count must wrap on the next clock; a design that only compares for equality would instead run the count up to its full range. Both shutdown modes are tested at both polarities and at both output levels. A design that swapped the two modes, or that ignored polarity in abrupt mode, would leave the line at the wrong level. A design that let register writes reach a stopped channel in graceful mode would change the frozen output. The bench also checks the full-duty, zero-duty, over-range-duty and zero-period corners, and that a re-enabled channel starts a fresh period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] A_DUTY   = 2'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd3;

  localparam int B_EN     = 0;
  localparam int B_POL    = 1;
  localparam int B_ABRUPT = 9;

  typedef struct packed {
    logic abrupt;
    logic pol;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  count,
  output logic [W-1:0]  bus_rdata,
  output ctrl_t         ctrl,
  output logic [W-1:0]  period,
  output logic [W-1:0]  duty
);
  logic [W-1:0] ctrl_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      period <= '0;
      duty   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL: begin
          ctrl.en     <= bus_wdata[B_EN];
          ctrl.pol    <= bus_wdata[B_POL];
          ctrl.abrupt <= bus_wdata[B_ABRUPT];
        end
        A_PERIOD: period <= bus_wdata;
        A_DUTY:   duty   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[B_EN]     = ctrl.en;
    ctrl_word[B_POL]    = ctrl.pol;
    ctrl_word[B_ABRUPT] = ctrl.abrupt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:   bus_rdata <= ctrl_word;
        A_PERIOD: bus_rdata <= period;
        A_DUTY:   bus_rdata <= duty;
        default:  bus_rdata <= count;
      endcase
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] period,
  output logic [W-1:0] count
);
  logic at_end;

  always_comb begin
    if (period == '0) at_end = 1'b1;
    else              at_end = (count >= period - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)  count <= '0;
    else if (at_end) count <= '0;
    else             count <= count + 1'b1;
  end

  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (count == '0));

  assert_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $stable(period) && period != '0) |-> (count < period));
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
  import pwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_t        ctrl,
  input  logic [W-1:0] count,
  input  logic [W-1:0] duty,
  output logic         pwm_out
);
  logic in_active;

  assign in_active = (count < duty);

  always_ff @(posedge clk) begin
    if (rst)                pwm_out <= 1'b0;
    else if (ctrl.en)       pwm_out <= in_active ? ~ctrl.pol : ctrl.pol;
    else if (ctrl.abrupt)   pwm_out <= ctrl.pol;
    else                    pwm_out <= pwm_out;
  end

  assert_active_level_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && count < duty) |=> (pwm_out == !$past(ctrl.pol)));

  assert_inactive_level_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && count >= duty) |=> (pwm_out == $past(ctrl.pol)));

  assert_abrupt_inactive_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && ctrl.abrupt) |=> (pwm_out == $past(ctrl.pol)));

  assert_graceful_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !ctrl.abrupt) |=> $stable(pwm_out));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          pwm_out
);
  ctrl_t        ctrl;
  logic [W-1:0] period;
  logic [W-1:0] duty;
  logic [W-1:0] count;

  pwm_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .count(count), .bus_rdata(bus_rdata),
    .ctrl(ctrl), .period(period), .duty(duty)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl.en), .period(period), .count(count)
  );

  pwm_outstage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .ctrl(ctrl), .count(count), .duty(duty),
    .pwm_out(pwm_out)
  );
endmodule

// File: tb/pwm_chan_test.sv
module pwm_chan_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;

  pwm_chan uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic highs(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic t_reset;
    int v;
    chk("R1 pwm_out", pwm_out, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 period", v, 0);
    rd(2, v); chk("R1 duty", v, 0);
    rd(3, v); chk("R1 count", v, 0);
  endtask

  task automatic t_readback;
    int v;
    wr(1, 16'hA5C3); rd(1, v); chk("R2 period readback", v, 16'hA5C3);
    wr(2, 16'h1234); rd(2, v); chk("R2 duty readback", v, 16'h1234);
    wr(0, 16'hFDFE); rd(0, v); chk("R2 ctrl defined bits", v, 16'h0002);
    wr(0, 16'h0200); rd(0, v); chk("R2 ctrl bit9", v, 16'h0200);
    chk("R2 output untouched", pwm_out, 0);
  endtask

  task automatic t_pwm;
    int h, f;
    wr(1, 10); wr(2, 3);
    wr(0, 16'h0201);
    highs(1, f); chk("R9 first cycle after enable active", f, 1);
    highs(39, h); chk("R4 period10 duty3 highs", h + f, 12);
    wr(0, 16'h0200);
    wr(1, 20); wr(2, 7);
    wr(0, 16'h0201);
    highs(60, h); chk("R4 period20 duty7 highs", h, 21);
    wr(1, 10); wr(2, 3);
    highs(5, h);
    wr(0, 16'h0200);
    wr(0, 16'h0201);
    highs(3, h); chk("R9 restart from zero", h, 3);
    highs(7, h); chk("R9 rest of restarted period", h, 0);
  endtask

  task automatic t_full;
    int h, v;
    wr(0, 16'h0200);
    wr(1, 8); wr(2, 8); wr(0, 16'h0201);
    highs(32, h); chk("R5 duty equals period", h, 32);
    wr(2, 12); highs(1, h);
    highs(32, h); chk("R5 duty above period", h, 32);
    wr(2, 0); highs(1, h);
    highs(32, h); chk("R5 duty zero", h, 0);
    wr(1, 0); wr(2, 1); highs(1, h);
    highs(20, h); chk("R3 period zero output", h, 20);
    rd(3, v); chk("R3 period zero count", v, 0);
  endtask

  task automatic t_duty_now;
    int h;
    wr(0, 16'h0200);
    wr(1, 100); wr(2, 10); wr(0, 16'h0201);
    highs(30, h);
    wr(2, 100);
    highs(20, h); chk("R6 duty raise acts mid-period", h, 20);
  endtask

  task automatic t_pol;
    int h;
    wr(0, 16'h0200);
    wr(1, 16); wr(2, 0); wr(0, 16'h0201);
    highs(1, h); chk("R7 pol0 inactive low", h, 0);
    wr(0, 16'h0203);
    highs(1, h); chk("R7 pol1 acts next cycle", h, 1);
    wr(0, 16'h0200);
    wr(2, 4); wr(0, 16'h0203);
    highs(32, h); chk("R7 pol1 active low count", h, 24);
  endtask

  task automatic t_shrink;
    int a, b, h;
    wr(0, 16'h0200);
    wr(1, 200); wr(2, 5); wr(0, 16'h0201);
    highs(150, h);
    wr(1, 10);
    highs(1, a); chk("R8 cycle before wrap", a, 0);
    highs(1, b); chk("R8 wrap next clock", b, 1);
    highs(10, h); chk("R8 new period pattern", h, 5);
  endtask

  task automatic t_abrupt;
    int h, v;
    wr(0, 16'h0200);
    wr(1, 8); wr(2, 8); wr(0, 16'h0201);
    highs(1, h); chk("R10 setup active high", h, 1);
    wr(0, 16'h0200);
    highs(1, h); chk("R10 abrupt pol0 to low", h, 0);
    rd(3, v); chk("R9 count zero while disabled", v, 0);
    wr(0, 16'h0203);
    highs(1, h); chk("R10 setup active low", h, 0);
    wr(0, 16'h0202);
    highs(1, h); chk("R10 abrupt pol1 to high", h, 1);
  endtask

  task automatic t_graceful;
    int h;
    wr(0, 16'h0200);
    wr(1, 8); wr(2, 8); wr(0, 16'h0001);
    highs(1, h); chk("R11 setup active", h, 1);
    wr(0, 16'h0000);
    highs(20, h); chk("R11 hold active level", h, 20);
    wr(2, 0); wr(0, 16'h0002);
    highs(10, h); chk("R11 writes while disabled ignored", h, 10);
    wr(0, 16'h0000);
    wr(2, 0); wr(0, 16'h0001);
    highs(1, h); chk("R11 setup inactive", h, 0);
    wr(0, 16'h0000);
    highs(20, h); chk("R11 hold inactive level", h, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_pwm();
    t_full();
    t_duty_now();
    t_pol();
    t_shrink();
    t_abrupt();
    t_graceful();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule